// File: doc/BRIEF.md
# Frame Sync Acquisition State Machine

This block finds and tracks frame alignment on a received serial bit stream that carries a fixed 14-bit sync word at the start of every frame. One bit arrives per clock. The block keeps the last 14 received bits and compares them against a programmed pattern. It counts how many bits agree and notes whether all of them agree. A frame-position counter holds the expected location of the next sync word. A small state machine moves between three states: Out Of Sync, In Sync, and a counted chain of Sync Errored states.

While Out Of Sync, the block hunts every bit position for an exact copy of the pattern. It declares In Sync once it has seen a programmable number of exact copies, each one frame apart. While In Sync, any damaged sync word moves it to Sync Errored. In that state a damaged word is tolerated if enough of its bits match. A word below the tolerance counts as a missed frame. Each miss also widens the search by one quat (two bits) on either side of the expected location. An exact word anywhere on that grid restores In Sync and re-centres the frame timing. Too many misses drop the block back to Out Of Sync.

The outputs are the state, the counter that belongs to the state, and a one-clock frame-start strobe that follows the located sync word. The frame length must exceed four times the largest loss criterion in bits, so that search windows of adjacent frames cannot overlap.

Top module: `fsync_acq`

## Requirements
- R1: After reset, `sync_state` is 0 (Out Of Sync), `state_cnt` is 0 and `frame_start` is 0.
- R2: The comparison window is the last 14 received bits, with `sync_pat[13]` compared against the earliest of them. While hunting (Out Of Sync with `state_cnt` 0), an exact match at any bit position is taken as a candidate, and the frame timing is aligned to that position. The counter then becomes 1, or the block goes straight to In Sync if the acquire criterion is 1.
- R3: In Out Of Sync, `state_cnt` shows the exact matches seen so far. Each further exact match exactly `FRAME_BITS` bits after the previous one increments it, and reaching `acq_crit` moves the block to In Sync with the counter at 0. A non-exact word at that expected position restarts the hunt with the counter at 0. An `acq_crit` of 0 acts as 1.
- R4: In Sync is held, with `state_cnt` 0, for as long as every expected sync word is exact.
- R5: In In Sync, a non-exact word at the expected position moves the block to Sync Errored with `state_cnt` 1. If `loss_crit` is 0 or 1, it moves to Out Of Sync with `state_cnt` 0 instead.
- R6: In Sync Errored, a non-exact word at the expected position whose matching-bit count is at least `match_thresh` leaves `state_cnt`, and so the search width, unchanged.
- R7: In Sync Errored, a word below `match_thresh` is a miss, resolved when the position reaches +2×`state_cnt` bits past the expected location. The counter then increments, or the block enters Out Of Sync with counter 0 once the incremented count reaches `loss_crit`.
- R8: In Sync Errored with count k, an exact word at any even bit offset within ±2k of the expected location moves the block to In Sync with `state_cnt` 0 and re-centres the frame timing on that word.
- R9: While In Sync or Sync Errored, `frame_start` is high for exactly one clock: the clock after the last bit of a located or expected sync word has entered the block. After a re-centring, it follows the new position.
- R10: `sync_state` encodes Out Of Sync as 0, In Sync as 1 and Sync Errored as 2, and is never 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial data bit |
| sync_pat | input | SYNC_W | Programmed sync pattern, MSB received first |
| match_thresh | input | MW | Minimum matching bits for a tolerated word in Sync Errored |
| acq_crit | input | CW | Exact words needed to declare In Sync |
| loss_crit | input | CW | Missed-frame count that declares Out Of Sync |
| sync_state | output | 2 | Current state: 0 Out Of Sync, 1 In Sync, 2 Sync Errored |
| state_cnt | output | CW | Acquisition count or missed-frame count |
| frame_start | output | 1 | One-clock strobe following the sync word |

## Verification
The bound checker watches the invariants on every clock. The state code stays legal, the counter is zero when locked, and the errored count stays between one and the loss limit and only grows by one. A miss at the expected position while locked always lands in Sync Errored with count one, a grid hit always locks with a strobe on the next clock, and the strobe never lasts two clocks. The rest can only be shown by the bench's frame scenarios. These are the acquire and loss counts against their criteria, the tolerance decision against the threshold, the widening window that accepts a word slipped by whole quats, and the strobe moving to the new alignment. The bench compares them cycle by cycle with a reference model driven by random frames, slips and damaged words.

// File: rtl/fsync_pkg.sv
`timescale 1ns/1ps
package fsync_pkg;

  typedef enum logic [1:0] {
    ST_OOS  = 2'd0,
    ST_LOCK = 2'd1,
    ST_ERR  = 2'd2
  } fsync_state_e;

  // A criterion of zero behaves as one.
  function automatic int crit_floor(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // Frame position folded to a signed distance from the expected sync end.
  function automatic int grid_offset(input int pos, input int frame);
    return (pos > frame / 2) ? pos - frame : pos;
  endfunction

  // True when pos lies on the quat grid within +/- half_q quats.
  function automatic logic on_search_grid(input int pos, input int frame, input int half_q);
    int d;
    d = grid_offset(pos, frame);
    return ((d % 2) == 0) && (d <= 2 * half_q) && (d >= -2 * half_q);
  endfunction

endpackage

// File: rtl/fsync_corr.sv
`timescale 1ns/1ps
module fsync_corr #(
  parameter int SYNC_W = 14,
  parameter int MW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic [SYNC_W-1:0] pat,
  output logic              exact,
  output logic [MW-1:0]     mcount
);
  logic [SYNC_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[SYNC_W-2:0], rx_bit};
  end

  always_comb begin
    mcount = '0;
    for (int i = 0; i < SYNC_W; i++)
      mcount = mcount + {{(MW-1){1'b0}}, ~(sr_q[i] ^ pat[i])};
    exact = (sr_q == pat);
  end
endmodule

// File: rtl/fsync_pos.sv
`timescale 1ns/1ps
module fsync_pos #(
  parameter int FRAME_BITS = 64,
  parameter int PW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          realign,
  output logic [PW-1:0] fpos
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)         fpos <= '0;
    else if (realign)   fpos <= PW'(1);
    else if (fpos == LAST) fpos <= '0;
    else                fpos <= fpos + PW'(1);
  end
endmodule

// File: rtl/fsync_ctrl.sv
`timescale 1ns/1ps
module fsync_ctrl
  import fsync_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int PW         = 6,
  parameter int CW         = 4,
  parameter int MW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exact,
  input  logic [MW-1:0] mcount,
  input  logic [MW-1:0] thresh,
  input  logic [PW-1:0] fpos,
  input  logic [CW-1:0] acq_crit,
  input  logic [CW-1:0] loss_crit,
  output fsync_state_e  state,
  output logic [CW-1:0] cnt,
  output logic          realign,
  output logic          win_hit
);
  fsync_state_e  state_d;
  logic [CW-1:0] cnt_d;
  logic          pend_q, pend_d, tol_q, tol_d;
  logic          at_exp, win_end, tol_met;
  int            acq_n, loss_n, cnt_i;

  always_comb begin
    acq_n   = crit_floor(int'(acq_crit));
    loss_n  = crit_floor(int'(loss_crit));
    cnt_i   = int'(cnt);
    at_exp  = (fpos == '0);
    win_end = (int'(fpos) == 2 * cnt_i);
    tol_met = (mcount >= thresh);
    win_hit = (state == ST_ERR) && exact && on_search_grid(int'(fpos), FRAME_BITS, cnt_i);

    state_d = state;
    cnt_d   = cnt;
    pend_d  = pend_q;
    tol_d   = tol_q;
    realign = 1'b0;

    unique case (state)
      ST_OOS: begin
        if (cnt == '0) begin
          if (exact) begin
            realign = 1'b1;
            if (acq_n == 1) state_d = ST_LOCK;
            else            cnt_d   = CW'(1);
          end
        end else if (at_exp) begin
          if (!exact)                  cnt_d = '0;
          else if (cnt_i + 1 >= acq_n) begin state_d = ST_LOCK; cnt_d = '0; end
          else                         cnt_d = CW'(cnt_i + 1);
        end
      end
      ST_LOCK: begin
        if (at_exp && !exact) begin
          pend_d = 1'b0;
          if (loss_n == 1) begin state_d = ST_OOS; cnt_d = '0; end
          else             begin state_d = ST_ERR; cnt_d = CW'(1); end
        end
      end
      ST_ERR: begin
        if (win_hit) begin
          realign = 1'b1;
          state_d = ST_LOCK;
          cnt_d   = '0;
        end else if (at_exp) begin
          pend_d = 1'b1;
          tol_d  = tol_met;
        end else if (pend_q && win_end) begin
          pend_d = 1'b0;
          if (!tol_q) begin
            if (cnt_i + 1 >= loss_n) begin state_d = ST_OOS; cnt_d = '0; end
            else                     cnt_d = CW'(cnt_i + 1);
          end
        end
      end
      default: begin
        state_d = ST_OOS;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_OOS;
      cnt    <= '0;
      pend_q <= 1'b0;
      tol_q  <= 1'b0;
    end else begin
      state  <= state_d;
      cnt    <= cnt_d;
      pend_q <= pend_d;
      tol_q  <= tol_d;
    end
  end
endmodule

// File: rtl/fsync_acq.sv
`timescale 1ns/1ps
module fsync_acq
  import fsync_pkg::*;
#(
  parameter int SYNC_W     = 14,
  parameter int FRAME_BITS = 64,
  parameter int CW         = 4,
  parameter int MW         = $clog2(SYNC_W + 1),
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic [SYNC_W-1:0] sync_pat,
  input  logic [MW-1:0]     match_thresh,
  input  logic [CW-1:0]     acq_crit,
  input  logic [CW-1:0]     loss_crit,
  output logic [1:0]        sync_state,
  output logic [CW-1:0]     state_cnt,
  output logic              frame_start
);
  logic          exact_w, realign_w, win_hit_w;
  logic [MW-1:0] mcount_w;
  logic [PW-1:0] fpos_w;
  fsync_state_e  state_w;

  fsync_corr #(.SYNC_W(SYNC_W), .MW(MW)) i_corr (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .pat(sync_pat),
    .exact(exact_w), .mcount(mcount_w)
  );

  fsync_pos #(.FRAME_BITS(FRAME_BITS), .PW(PW)) i_pos (
    .clk(clk), .rst_n(rst_n), .realign(realign_w), .fpos(fpos_w)
  );

  fsync_ctrl #(.FRAME_BITS(FRAME_BITS), .PW(PW), .CW(CW), .MW(MW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .exact(exact_w), .mcount(mcount_w),
    .thresh(match_thresh), .fpos(fpos_w), .acq_crit(acq_crit),
    .loss_crit(loss_crit), .state(state_w), .cnt(state_cnt),
    .realign(realign_w), .win_hit(win_hit_w)
  );

  assign sync_state  = state_w;
  assign frame_start = (state_w != ST_OOS) && (fpos_w == PW'(1));
endmodule

// File: rtl/fsync_acq_chk.sv
`timescale 1ns/1ps
module fsync_acq_chk #(
  parameter int CW = 4,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sync_state,
  input logic [CW-1:0] state_cnt,
  input logic          frame_start,
  input logic [CW-1:0] loss_crit,
  input logic          exact,
  input logic          win_hit,
  input logic [PW-1:0] fpos
);
  logic [CW-1:0] loss_eff;
  assign loss_eff = (loss_crit == '0) ? CW'(1) : loss_crit;

  a_r10_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    sync_state != 2'd3);

  a_r4_lock_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd1) |-> (state_cnt == '0));

  a_r7_err_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd2) |-> (state_cnt != '0 && state_cnt < loss_eff));

  a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd2) |=> (sync_state != 2'd2 || state_cnt == $past(state_cnt)
                              || state_cnt == $past(state_cnt) + CW'(1)));

  a_r5_miss_enters_err: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd1 && fpos == '0 && !exact && loss_eff > CW'(1))
      |=> (sync_state == 2'd2 && state_cnt == CW'(1)));

  a_r8_grid_hit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |=> (sync_state == 2'd1 && state_cnt == '0 && frame_start));

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

bind fsync_acq fsync_acq_chk #(.CW(CW), .PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .sync_state(sync_state), .state_cnt(state_cnt),
  .frame_start(frame_start), .loss_crit(loss_crit), .exact(exact_w),
  .win_hit(win_hit_w), .fpos(fpos_w)
);

// File: tb/test_fsync_acq.sv
`timescale 1ns/1ps
module test_fsync_acq;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 14;
  localparam int FB = 64;
  localparam int CW = 4;
  localparam int MW = 4;

  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b0;
  logic [SW-1:0] pat = 14'b10110011100001;
  logic [MW-1:0] thresh = 4'd12;
  logic [CW-1:0] acq = 4'd2, loss = 4'd6;
  logic [1:0] sync_state;
  logic [CW-1:0] state_cnt;
  logic frame_start;

  fsync_acq #(.SYNC_W(SW), .FRAME_BITS(FB), .CW(CW)) i_fsync_acq (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sync_pat(pat),
    .match_thresh(thresh), .acq_crit(acq), .loss_crit(loss),
    .sync_state(sync_state), .state_cnt(state_cnt), .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // reference model: anchor holds the index of the bit that ended the last located word
  int m_state, m_cnt, m_anchor, m_bitn;
  bit m_pend, m_tolok;
  logic [SW-1:0] m_sr;
  string m_tag;
  bit fs_first;
  int fs_count;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  function automatic int floor1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int model_pos();
    return (m_bitn - m_anchor) % FB;
  endfunction

  function automatic int signed_dist(input int p);
    if (2 * p > FB) return p - FB;
    return p;
  endfunction

  task automatic model_reset();
    m_state = 0; m_cnt = 0; m_anchor = 0; m_bitn = 0;
    m_pend = 0; m_tolok = 0; m_sr = '0; m_tag = "R1";
  endtask

  task automatic model_decide();
    int p, d, agree, la, ll;
    bit ex;
    p = model_pos();
    d = signed_dist(p);
    ex = (m_sr == pat);
    agree = SW - $countones(m_sr ^ pat);
    la = floor1(int'(acq));
    ll = floor1(int'(loss));
    if (m_state == 0) begin
      if (m_cnt == 0) begin
        if (ex) begin
          m_anchor = m_bitn;
          m_tag = "R2";
          if (la == 1) m_state = 1; else m_cnt = 1;
        end
      end else if (p == 0) begin
        m_tag = "R3";
        if (!ex) m_cnt = 0;
        else if (m_cnt + 1 >= la) begin m_state = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
    end else if (m_state == 1) begin
      if (p == 0 && ex) m_tag = "R4";
      if (p == 0 && !ex) begin
        m_tag = "R5";
        m_pend = 0;
        if (ll == 1) begin m_state = 0; m_cnt = 0; end
        else begin m_state = 2; m_cnt = 1; end
      end
    end else begin
      if (ex && (d % 2 == 0) && d <= 2 * m_cnt && d >= -2 * m_cnt) begin
        m_tag = "R8";
        m_state = 1; m_cnt = 0; m_anchor = m_bitn;
      end else if (p == 0) begin
        m_tag = "R6";
        m_pend = 1; m_tolok = (agree >= int'(thresh));
      end else if (m_pend && d == 2 * m_cnt) begin
        m_pend = 0;
        if (!m_tolok) begin
          m_tag = "R7";
          if (m_cnt + 1 >= ll) begin m_state = 0; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end
    end
  endtask

  task automatic step(input bit b);
    int p, exp_pack, act_pack;
    bit exp_fs;
    rx_bit = b;
    @(posedge clk);
    #1;
    m_bitn++;
    m_sr = {m_sr[SW-2:0], b};
    p = model_pos();
    exp_fs = (m_state != 0) && (p == 1);
    exp_pack = m_state * 64 + m_cnt * 2 + int'(exp_fs);
    act_pack = int'(sync_state) * 64 + int'(state_cnt) * 2 + int'(frame_start);
    check(act_pack == exp_pack, m_tag, act_pack, exp_pack);
    check(sync_state != 2'd3, "R10", int'(sync_state), 0);
    if (frame_start) fs_count++;
    model_decide();
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    rx_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    model_reset();
    check(sync_state == 2'd0 && state_cnt == '0 && frame_start == 1'b0, "R1",
          int'(sync_state) * 16 + int'(state_cnt), 0);
    rst_n = 1'b1;
  endtask

  // word first, then payload, len bits in all
  task automatic send_frame(input logic [SW-1:0] word, input int len, input bit rnd);
    fs_count = 0;
    for (int i = 0; i < SW; i++) step(word[SW-1-i]);
    for (int j = 0; j < len - SW; j++) begin
      step(rnd ? 1'($urandom % 2) : 1'b0);
      if (j == 0) fs_first = frame_start;
    end
  endtask

  task automatic expect_state(input int st, input int cn, input string tag);
    check(int'(sync_state) == st && int'(state_cnt) == cn, tag,
          int'(sync_state) * 16 + int'(state_cnt), st * 16 + cn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] rev, w;
    int kind, len;
    void'($urandom(32'd5501));
    for (int i = 0; i < SW; i++) rev[i] = pat[SW-1-i];

    apply_reset();
    // R2: bit-reversed word must not be located
    send_frame(rev, FB, 0);
    expect_state(0, 0, "R2");
    for (int i = 0; i < 5; i++) step(1'b0);
    send_frame(pat, FB, 0);
    expect_state(0, 1, "R2");
    send_frame(pat, FB, 0);
    expect_state(1, 0, "R3");
    send_frame(pat, FB, 0);
    expect_state(1, 0, "R4");
    check(fs_first == 1'b1 && fs_count == 1, "R9", fs_count, 1);
    send_frame(pat ^ 14'd1, FB, 0);
    expect_state(2, 1, "R5");
    send_frame(pat ^ 14'd1, FB, 0);
    expect_state(2, 1, "R6");
    send_frame('0, FB, 0);
    expect_state(2, 2, "R7");
    for (int i = 0; i < 3; i++) send_frame('0, FB, 0);
    expect_state(2, 5, "R7");
    send_frame('0, FB, 0);
    expect_state(0, 0, "R7");
    // re-acquire, then recover from a two-quat early slip
    send_frame(pat, FB, 0);
    send_frame(pat, FB, 0);
    expect_state(1, 0, "R3");
    send_frame('0, FB, 0);
    expect_state(2, 1, "R5");
    send_frame('0, FB - 4, 0);
    expect_state(2, 2, "R7");
    send_frame(pat, FB, 0);
    expect_state(1, 0, "R8");
    check(fs_first == 1'b1, "R9", int'(fs_first), 1);
    send_frame(pat, FB, 0);
    expect_state(1, 0, "R8");
    check(fs_first == 1'b1 && fs_count == 1, "R9", fs_count, 1);

    // random rounds against the reference model
    for (int r = 0; r < 5; r++) begin
      rst_n = 1'b0;
      pat = 14'($urandom) | 14'h2001;
      acq = CW'($urandom % 4);
      loss = CW'($urandom % 9);
      thresh = MW'(9 + $urandom % 6);
      apply_reset();
      for (int f = 0; f < 60; f++) begin
        kind = $urandom % 10;
        len = FB;
        w = pat;
        if (kind == 5) w = pat ^ (14'd1 << ($urandom % SW));
        else if (kind == 6) w = 14'($urandom);
        else if (kind == 7) len = ($urandom % 2 == 1) ? FB + 2 * (1 + $urandom % 3)
                                                      : FB - 2 * (1 + $urandom % 3);
        else if (kind == 8) w = '0;
        send_frame(w, len, 1);
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule